// File: doc/BRIEF.md
# DTMF Guard-Time Steering and Output Latch

This block replaces the resistor-capacitor timing network that usually sits behind a dual-tone detector. It watches the detector's early flag, which says that a valid tone pair is present right now, and the 4-bit key code that goes with it. A digit counts only once the flag has stayed high for a programmable tone-present guard time. At that point the block captures the code in an output latch and, a fixed number of clock cycles later, raises a delayed steering output. A digit ends only once the flag has stayed low for a separate tone-absent guard time. Short bursts are therefore rejected and short dropouts inside a digit are absorbed.

Guard times are counted in ticks of a divided timebase. Both limits are 16-bit values. The block takes them from configuration inputs while reset is high and holds them until the next reset, so the present and absent times are set independently of each other. The latched code stays on the data outputs after the tone ends and changes only when the next digit registers. A separate registered drive-enable tells the pad ring whether to drive the data bus or leave it floating. A power-down input freezes every timer and all steering state.

Top module: `tone_steer`

## Requirements
- R1: While reset is high, `steer_out` is 0 and `data_q` is 0. The configuration inputs are captured as the present and absent limits.
- R2: When `early_flag` stays high for at least `P*TICK_DIV` clock cycles (P is the captured present limit), the code on `det_code` is written to `data_q` and `steer_out` later rises, once per digit.
- R3: A burst of `early_flag` lasting at most `(P-1)*TICK_DIV` cycles is rejected: `steer_out` stays 0 and `data_q` is unchanged.
- R4: `data_q` takes the new code exactly `SETUP_CYC` clock cycles before `steer_out` rises, and `data_q` does not change on the edge where `steer_out` rises.
- R5: Once `steer_out` is high, it falls within `A*TICK_DIV+2` cycles after `early_flag` goes low (A is the captured absent limit). A low gap of at most `(A-1)*TICK_DIV` cycles leaves `steer_out` high and `data_q` unchanged.
- R6: `data_q` keeps the last registered code after `steer_out` falls, and it changes only when a new digit registers.
- R7: The present and absent limits act independently: a long present limit with a short absent limit gives slow acceptance together with fast release.
- R8: A partly counted present guard restarts from zero whenever `early_flag` drops. Two sub-threshold bursts with a short gap between them do not register, even if their sum exceeds the limit.
- R9: `data_drive` equals `out_en` delayed by one clock, whatever the steering state. High means drive `data_q` onto the bus and low means high impedance.
- R10: While `pwr_down` is high, the timebase, guard timers and steering state are frozen. A flag change during that time neither registers nor releases a digit.
- R11: After reset, a change on `cfg_present` or `cfg_absent` has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; captures limits |
| pwr_down | input | 1 | High freezes all timing and state |
| early_flag | input | 1 | Detector reports a valid tone pair |
| det_code | input | CODE_W | Key code from the detector |
| out_en | input | 1 | Bus enable request (1 = drive) |
| cfg_present | input | GUARD_W | Tone-present guard limit in ticks |
| cfg_absent | input | GUARD_W | Tone-absent guard limit in ticks |
| steer_out | output | 1 | Delayed steering: a registered digit is active |
| data_q | output | CODE_W | Latched code of the last registered digit |
| data_drive | output | 1 | Registered bus drive enable for the pads |

## Verification
On every cycle, the assertions check that the data are steady when steering rises, that the latch moves only on a registration, that the drive enable tracks its request, that power-down freezes the timebase and the controller, that steering cannot drop while the flag is present, and that the captured limits never change outside reset. Only the bench's scenarios can show the duration behaviour. These are the accept and reject bounds for bursts and dropouts, the restart of a partial count across a short gap, the swap of long and short limits between two resets, and the exact spacing from the data update to the steering edge as a scoreboard of expected codes is consumed.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_HELD  = 2'd2
  } steer_state_e;
endpackage

// File: rtl/tone_tick_gen.sv
module tone_tick_gen #(
  parameter int TICK_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      tick_o  <= 1'b0;
    end else if (hold) begin
      tick_o  <= 1'b0;
    end else if (div_cnt == LAST) begin
      div_cnt <= '0;
      tick_o  <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      tick_o  <= 1'b0;
    end
  end

  // R10: a frozen timebase emits no tick
  assert_no_tick_in_hold_R10: assert property (@(posedge clk) disable iff (rst)
    hold |=> !tick_o);

  generate
    if (TICK_DIV > 1) begin : g_spaced
      assert_tick_isolated_R2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tone_guard_fsm.sv
module tone_guard_fsm
  import tone_steer_pkg::*;
#(
  parameter int GUARD_W   = 16,
  parameter int SETUP_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic               tick,
  input  logic               flag,
  input  logic [GUARD_W-1:0] lim_present,
  input  logic [GUARD_W-1:0] lim_absent,
  output logic               load_o,
  output logic               steer_o
);
  localparam int SW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
  localparam logic [SW-1:0] SETUP_LAST = SW'(SETUP_CYC - 1);

  steer_state_e       state;
  logic [GUARD_W-1:0] gcnt;
  logic [GUARD_W:0]   gcnt_nx;
  logic [SW-1:0]      scnt;
  logic               present_done;
  logic               absent_done;

  assign gcnt_nx      = {1'b0, gcnt} + 1'b1;
  assign present_done = tick && (gcnt_nx >= {1'b0, lim_present});
  assign absent_done  = tick && (gcnt_nx >= {1'b0, lim_absent});
  assign load_o       = !hold && (state == ST_IDLE) && flag && present_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      gcnt    <= '0;
      scnt    <= '0;
      steer_o <= 1'b0;
    end else if (!hold) begin
      unique case (state)
        ST_IDLE: begin
          if (!flag)            gcnt <= '0;
          else if (present_done) begin
            gcnt  <= '0;
            scnt  <= '0;
            state <= ST_SETUP;
          end else if (tick)    gcnt <= gcnt_nx[GUARD_W-1:0];
        end
        ST_SETUP: begin
          if (scnt == SETUP_LAST) begin
            steer_o <= 1'b1;
            state   <= ST_HELD;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        ST_HELD: begin
          if (flag)             gcnt <= '0;
          else if (absent_done) begin
            gcnt    <= '0;
            steer_o <= 1'b0;
            state   <= ST_IDLE;
          end else if (tick)    gcnt <= gcnt_nx[GUARD_W-1:0];
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: power-down freezes the controller
  assert_freeze_in_hold_R10: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(state) && $stable(gcnt) && $stable(steer_o)));
  // R5: while the flag is present, a held digit cannot be released
  assert_held_with_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HELD && flag) |=> steer_o);
  // R2: the present counter never reaches its limit while idle
  assert_gcnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && lim_present != '0) |-> (gcnt < lim_present));
endmodule

// File: rtl/tone_out_stage.sv
module tone_out_stage #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              oe_req,
  output logic [CODE_W-1:0] data_o,
  output logic              drive_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      drive_o <= 1'b0;
    end else begin
      drive_o <= oe_req;
      if (load) data_o <= code;
    end
  end

  // R6: the latch holds between registrations
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(data_o));
  // R9: drive enable follows its request one cycle later
  assert_drive_follow_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drive_o == $past(oe_req)));
endmodule

// File: rtl/tone_steer.sv
module tone_steer #(
  parameter int TICK_DIV  = 8,
  parameter int GUARD_W   = 16,
  parameter int CODE_W    = 4,
  parameter int SETUP_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_down,
  input  logic               early_flag,
  input  logic [CODE_W-1:0]  det_code,
  input  logic               out_en,
  input  logic [GUARD_W-1:0] cfg_present,
  input  logic [GUARD_W-1:0] cfg_absent,
  output logic               steer_out,
  output logic [CODE_W-1:0]  data_q,
  output logic               data_drive
);
  logic               flag_r;
  logic [CODE_W-1:0]  code_r;
  logic [GUARD_W-1:0] lim_p;
  logic [GUARD_W-1:0] lim_a;
  logic               tick;
  logic               load;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_r <= 1'b0;
      code_r <= '0;
      lim_p  <= cfg_present;
      lim_a  <= cfg_absent;
    end else begin
      flag_r <= early_flag;
      code_r <= det_code;
    end
  end

  tone_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .hold(pwr_down), .tick_o(tick)
  );

  tone_guard_fsm #(.GUARD_W(GUARD_W), .SETUP_CYC(SETUP_CYC)) u_fsm (
    .clk(clk), .rst(rst), .hold(pwr_down), .tick(tick), .flag(flag_r),
    .lim_present(lim_p), .lim_absent(lim_a),
    .load_o(load), .steer_o(steer_out)
  );

  tone_out_stage #(.CODE_W(CODE_W)) u_out (
    .clk(clk), .rst(rst), .load(load), .code(code_r), .oe_req(out_en),
    .data_o(data_q), .drive_o(data_drive)
  );

  // R4: data are already settled on the steering edge
  assert_data_before_steer_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(steer_out) |-> $stable(data_q));
  // R6: release of a digit leaves the code in place
  assert_code_kept_on_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(steer_out) |-> $stable(data_q));
  // R11: captured limits change only under reset
  assert_limits_fixed_R11: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($stable(lim_p) && $stable(lim_a)));
endmodule

// File: tb/tone_steer_tb_top.sv
module tone_steer_tb_top;
  localparam int DIV = 4;
  localparam int SET = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_down = 1'b0;
  logic        early_flag = 1'b0;
  logic [3:0]  det_code = '0;
  logic        out_en = 1'b1;
  logic [15:0] cfg_present = 16'd5;
  logic [15:0] cfg_absent = 16'd8;
  logic        steer_out;
  logic [3:0]  data_q;
  logic        data_drive;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  logic [3:0] exp_q[$];

  always #5 clk = ~clk;

  tone_steer #(.TICK_DIV(DIV), .SETUP_CYC(SET)) dut_i (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .early_flag(early_flag),
    .det_code(det_code), .out_en(out_en), .cfg_present(cfg_present),
    .cfg_absent(cfg_absent), .steer_out(steer_out), .data_q(data_q),
    .data_drive(data_drive)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tone(input logic [3:0] c, input int len, input bit valid);
    early_flag = 1'b1;
    det_code   = c;
    if (valid) exp_q.push_back(c);
    idle(len);
    early_flag = 1'b0;
  endtask

  task automatic do_reset(input int p, input int a);
    rst = 1'b1;
    cfg_present = 16'(p);
    cfg_absent  = 16'(a);
    idle(3);
    chk(steer_out == 1'b0, "R1 steer in reset", int'(steer_out), 0);
    chk(data_q == 4'd0, "R1 data in reset", int'(data_q), 0);
    rst = 1'b0;
    idle(1);
  endtask

  // Monitor: pops the scoreboard on each steering rise
  logic [3:0] prev_data = '0;
  logic       prev_std = 1'b0;
  int         since_chg = 0;
  always @(negedge clk) begin
    if (rst) begin
      prev_std  = 1'b0;
      prev_data = data_q;
      since_chg = 0;
    end else begin
      if (data_q != prev_data) since_chg = 0;
      else since_chg++;
      if (steer_out && !prev_std) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected registration", int'(data_q), -1);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk(data_q == e, "R2 registered code", int'(data_q), int'(e));
          chk(since_chg == SET, "R4 data-to-steer spacing", since_chg, SET);
        end
      end
      prev_std  = steer_out;
      prev_data = data_q;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle(1);
    do_reset(5, 8);
    chk(data_drive == 1'b1, "R9 drive after reset", int'(data_drive), 1);

    // R11: limit port changes after reset are ignored
    cfg_present = 16'd1;
    tone(4'd1, 16, 0); idle(40);
    chk(steer_out == 1'b0, "R11 limit not reloaded", int'(steer_out), 0);
    chk(data_q == 4'd0, "R3 data unchanged by burst", int'(data_q), 0);

    // R3: short burst
    tone(4'd2, 8, 0); idle(40);
    chk(steer_out == 1'b0, "R3 short burst", int'(steer_out), 0);

    // R8: two partial bursts with a gap
    tone(4'd4, 16, 0); idle(2); tone(4'd4, 16, 0); idle(40);
    chk(steer_out == 1'b0, "R8 restart on toggle", int'(steer_out), 0);
    chk(data_q == 4'd0, "R8 data unchanged", int'(data_q), 0);

    // R2/R6: full digit then pause
    tone(4'd5, 60, 1); idle(60);
    chk(steer_out == 1'b0, "R5 released after pause", int'(steer_out), 0);
    chk(data_q == 4'd5, "R6 code held after tone", int'(data_q), 5);

    // R5: dropout tolerance and release timing
    early_flag = 1'b1; det_code = 4'd9; exp_q.push_back(4'd9);
    idle(40);
    chk(steer_out == 1'b1, "R2 digit active", int'(steer_out), 1);
    early_flag = 1'b0; idle(28);
    chk(steer_out == 1'b1, "R5 dropout tolerated", int'(steer_out), 1);
    early_flag = 1'b1; idle(10);
    chk(data_q == 4'd9, "R5 code kept over dropout", int'(data_q), 9);
    early_flag = 1'b0; idle(28);
    chk(steer_out == 1'b1, "R5 still held before limit", int'(steer_out), 1);
    idle(8);
    chk(steer_out == 1'b0, "R5 release after absent limit", int'(steer_out), 0);
    idle(50);
    chk(data_q == 4'd9, "R6 code held in pause", int'(data_q), 9);

    // R9: bus drive enable
    out_en = 1'b0; idle(2);
    chk(data_drive == 1'b0, "R9 drive off", int'(data_drive), 0);
    chk(data_q == 4'd9, "R9 latch unaffected", int'(data_q), 9);
    out_en = 1'b1; idle(2);
    chk(data_drive == 1'b1, "R9 drive on", int'(data_drive), 1);

    // R10: power-down while a digit is held
    early_flag = 1'b1; det_code = 4'd3; exp_q.push_back(4'd3);
    idle(40);
    pwr_down = 1'b1; early_flag = 1'b0; idle(100);
    chk(steer_out == 1'b1, "R10 no release in power-down", int'(steer_out), 1);
    early_flag = 1'b1; idle(2); pwr_down = 1'b0; idle(10);
    chk(steer_out == 1'b1, "R10 held after wake", int'(steer_out), 1);
    early_flag = 1'b0; idle(50);
    chk(steer_out == 1'b0, "R10 release after wake", int'(steer_out), 0);

    // R10: power-down while idle
    pwr_down = 1'b1; early_flag = 1'b1; det_code = 4'd7; idle(100);
    chk(steer_out == 1'b0, "R10 no registration in power-down", int'(steer_out), 0);
    chk(data_q == 4'd3, "R10 latch frozen", int'(data_q), 3);
    early_flag = 1'b0; idle(2); pwr_down = 1'b0; idle(40);
    chk(steer_out == 1'b0, "R10 nothing after wake", int'(steer_out), 0);

    // R7: long present limit, short absent limit
    do_reset(8, 2);
    tone(4'd6, 28, 0); idle(20);
    chk(steer_out == 1'b0, "R7 long present rejects burst", int'(steer_out), 0);
    early_flag = 1'b1; det_code = 4'd12; exp_q.push_back(4'd12);
    idle(45);
    chk(steer_out == 1'b1, "R7 accepted after long guard", int'(steer_out), 1);
    early_flag = 1'b0; idle(4); early_flag = 1'b1; idle(10);
    chk(steer_out == 1'b1, "R7 short dropout tolerated", int'(steer_out), 1);
    early_flag = 1'b0; idle(12);
    chk(steer_out == 1'b0, "R7 fast release", int'(steer_out), 0);
    chk(data_q == 4'd12, "R7 code held", int'(data_q), 12);

    idle(5);
    chk(exp_q.size() == 0, "R2 all expected digits seen", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule